// File: doc/BRIEF.md
# Interrupt status, enable and vector logic

This block keeps one 8-bit status and enable register for a small microcontroller core. It latches three dedicated interrupt flags: an edge on an external interrupt pin, a timer overflow, and an edge on the timer clock pin. The edge detection and polarity choice happen upstream, so each source arrives as a single-cycle event pulse. The block also forms a read-only summary bit from a bus of peripheral flag and enable pairs.

Each flag is gated by its own enable bit. Peripheral requests are gated a second time by a peripheral master enable. The block raises `irq` while any gated request is pending. It shows a fixed vector address for the highest-priority pending request. When the core acknowledges with a one-cycle pulse, the block clears the winning dedicated flag in hardware.

Software reaches the register through a simple read/write port at one address.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all register bits read 0, `irq` is 0 and `vec_addr` is 00h.
- R2: A write (sel=1, wr=1, addr=REG_ADDR) loads bits 6..0 from wdata on the next clock. Bit 7 ignores writes. A write to any other address changes nothing. `rdata` shows the register while sel=1 and addr=REG_ADDR, and shows 0 otherwise.
- R3: Bit 7 reads as the OR over all peripherals of (periph_flag AND periph_en). It follows those inputs in the same cycle.
- R4: An event pulse sets its flag on the next clock: `int_evt` sets bit 4, `tmr_evt` sets bit 5 and `tck_evt` sets bit 6.
- R5: The enable bits are: bit 0 for the pin flag, bit 1 for the timer flag, bit 2 for the clock-pin flag and bit 3 for the peripheral master enable. A flag requests only when its enable is 1. The peripheral summary requests only when bit 3 is also 1. `irq` is 1 exactly when some request is pending.
- R6: Pending requests are ranked pin, then timer, then clock-pin, then peripheral. `vec_addr` is 08h, 10h, 18h or 20h for the winner, and 00h when nothing is pending.
- R7: An `ack` pulse clears only the winning dedicated flag on the next clock. The other flags keep their values.
- R8: An `ack` while the peripheral request wins clears nothing. The peripheral request stays pending.
- R9: A set event beats both a software write and an `ack` clear to the same flag in the same cycle.
- R10: An `ack` clear beats a software write to the same flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | Write when 1, read when 0 |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| int_evt | input | 1 | Pin edge event pulse |
| tmr_evt | input | 1 | Timer overflow pulse |
| tck_evt | input | 1 | Timer clock-pin edge event pulse |
| periph_flag | input | NUM_PERIPH | Peripheral flags |
| periph_en | input | NUM_PERIPH | Peripheral enables |
| ack | input | 1 | Interrupt acknowledge pulse from the core |
| irq | output | 1 | Interrupt request |
| vec_addr | output | VEC_W | Vector of the winning request |

## Verification
The main check walks many register images through the flag and enable combinations. Three kinds of image are compared:
- A single flag with and without its enable separates gating from setting.
- Several enabled flags at once expose ranking errors.
- Peripheral pairs with matched and mismatched enable positions, and with the master enable on and off, separate the summary OR from its second gate.

Directed sequences then acknowledge repeatedly, so each clear must land on the right bit in order. They also collide event, write and acknowledge in one cycle to pin down which action wins.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_DED   = 3;
  localparam int NUM_SRC   = NUM_DED + 1;
  localparam int BIT_PSUM  = 7;
  localparam int BIT_FLAG0 = 4;
  localparam int BIT_PE    = 3;
  localparam int SRC_PER   = 3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic hw_clr,
  input  logic sw_wr,
  input  logic sw_val,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_evt | hw_clr | sw_wr;
    q_d  = q;
    if (set_evt)     q_d = 1'b1;
    else if (hw_clr) q_d = 1'b0;
    else if (sw_wr)  q_d = sw_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> q);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && (hw_clr || sw_wr)) |=> q);
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr && !set_evt) |=> !q);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !hw_clr && !sw_wr) |=> $stable(q));
endmodule

// File: rtl/irq_periph_sum.sv
module irq_periph_sum #(
  parameter int NUM_PERIPH = 8
) (
  input  logic [NUM_PERIPH-1:0] pflag,
  input  logic [NUM_PERIPH-1:0] pen,
  output logic                  psum
);
  logic [NUM_PERIPH-1:0] gated;

  always_comb begin
    gated = pflag & pen;
    psum  = |gated;
  end
endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
  parameter int NUM_SRC  = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] grant,
  output logic               any_req,
  output logic [VEC_W-1:0]   vec
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    vec   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        vec      = VEC_W'((i + 1) * VEC_STEP);
      end
    end
    any_req = found;
  end

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_idle_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (vec == '0));
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_DED-1:0] set_evt,
  input  logic [NUM_DED-1:0] clr_evt,
  input  logic               psum,
  output logic [NUM_DED-1:0] flags,
  output logic [NUM_SRC-1:0] ens,
  output logic [REG_W-1:0]   image
);
  logic [NUM_SRC-1:0] en_d;

  for (genvar g = 0; g < NUM_DED; g++) begin : g_flag
    irq_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt[g]),
      .hw_clr  (clr_evt[g]),
      .sw_wr   (wr_hit),
      .sw_val  (wdata[BIT_FLAG0 + g]),
      .q       (flags[g])
    );
  end

  always_comb en_d = wdata[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ens <= '0;
    else if (wr_hit) ens <= en_d;
  end

  always_comb image = {psum, flags, ens};

  assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ens == $past(wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h07,
  parameter int                NUM_PERIPH = 8,
  parameter int                VEC_W      = 8,
  parameter int                VEC_STEP   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic                  int_evt,
  input  logic                  tmr_evt,
  input  logic                  tck_evt,
  input  logic [NUM_PERIPH-1:0] periph_flag,
  input  logic [NUM_PERIPH-1:0] periph_en,
  input  logic                  ack,
  output logic                  irq,
  output logic [VEC_W-1:0]      vec_addr
);
  logic               rst_n_s;
  logic               hit;
  logic               wr_hit;
  logic               psum;
  logic [NUM_DED-1:0] flags;
  logic [NUM_DED-1:0] set_evt;
  logic [NUM_DED-1:0] clr_evt;
  logic [NUM_SRC-1:0] ens;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [REG_W-1:0]   image;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irq_periph_sum #(.NUM_PERIPH(NUM_PERIPH)) u_psum (
    .pflag (periph_flag),
    .pen   (periph_en),
    .psum  (psum)
  );

  always_comb begin
    hit     = sel && (addr == REG_ADDR);
    wr_hit  = hit && wr;
    set_evt = {tck_evt, tmr_evt, int_evt};
    clr_evt = ack ? grant[NUM_DED-1:0] : '0;
    req     = {psum & ens[BIT_PE], flags & ens[NUM_DED-1:0]};
    rdata   = hit ? image : '0;
  end

  irq_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_hit  (wr_hit),
    .wdata   (wdata),
    .set_evt (set_evt),
    .clr_evt (clr_evt),
    .psum    (psum),
    .flags   (flags),
    .ens     (ens),
    .image   (image)
  );

  irq_prio_vec #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req     (req),
    .grant   (grant),
    .any_req (irq),
    .vec     (vec_addr)
  );

  assert_irq_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (ens != '0));
  assert_per_noclear_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack && grant[SRC_PER]) |=> $stable(flags));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam logic [7:0] RA = 8'h07;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic       int_evt = 1'b0, tmr_evt = 1'b0, tck_evt = 1'b0, ack = 1'b0;
  logic [7:0] pf = 8'h00, pen = 8'h00;
  logic       irq;
  logic [7:0] vec_addr;
  int         total = 0, bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .int_evt(int_evt), .tmr_evt(tmr_evt), .tck_evt(tck_evt),
    .periph_flag(pf), .periph_en(pen), .ack(ack), .irq(irq), .vec_addr(vec_addr)
  );

  // fields: wr_val[32:25] pf[24:17] pen[16:9] irq[8] vec[7:0]
  localparam logic [32:0] VT [12] = '{
    {8'h00, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h11, 8'h00, 8'h00, 1'b1, 8'h08},
    {8'h10, 8'h00, 8'h00, 1'b0, 8'h00},
    {8'h22, 8'h00, 8'h00, 1'b1, 8'h10},
    {8'h44, 8'h00, 8'h00, 1'b1, 8'h18},
    {8'h77, 8'h00, 8'h00, 1'b1, 8'h08},
    {8'h66, 8'h00, 8'h00, 1'b1, 8'h10},
    {8'h08, 8'h01, 8'h01, 1'b1, 8'h20},
    {8'h00, 8'h01, 8'h01, 1'b0, 8'h00},
    {8'h08, 8'h01, 8'h02, 1'b0, 8'h00},
    {8'h4C, 8'h80, 8'h80, 1'b1, 8'h18},
    {8'h37, 8'hFF, 8'hFF, 1'b1, 8'h08}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ie, input logic te, input logic ke, input logic ak,
                     input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    int_evt = ie; tmr_evt = te; tck_evt = ke; ack = ak;
    sel = w; wr = w; addr = a; wdata = d;
    @(negedge clk);
    int_evt = 0; tmr_evt = 0; tck_evt = 0; ack = 0; sel = 0; wr = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    sel = 1; wr = 0; addr = RA;
    #1 d = rdata;
    sel = 0;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    rd(rv); chk("R1 reg", rv, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 vec", vec_addr, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5/R6/R3 table walk
    for (int i = 0; i < 12; i++) begin
      pf  = VT[i][24:17];
      pen = VT[i][16:9];
      cyc(0, 0, 0, 0, 1, RA, VT[i][32:25]);
      chk("R5 irq", {7'b0, irq}, {7'b0, VT[i][8]});
      chk("R6 vec", vec_addr, VT[i][7:0]);
      rd(rv);
      chk("R3 read", rv, {|(VT[i][24:17] & VT[i][16:9]), VT[i][31:25]});
    end
    pf = 0; pen = 0;

    // R2 bit 7 ignores writes, other address ignored, read off-address is 0
    cyc(0, 0, 0, 0, 1, RA, 8'h80);
    rd(rv); chk("R2 bit7", rv, 8'h00);
    cyc(0, 0, 0, 0, 1, 8'h08, 8'h7F);
    rd(rv); chk("R2 other addr", rv, 8'h00);
    sel = 1; addr = 8'h06; #1 chk("R2 off read", rdata, 8'h00); sel = 0;

    // R4 events set flags
    cyc(0, 1, 0, 0, 0, RA, 8'h00);
    rd(rv); chk("R4 tmr", rv, 8'h20);
    chk("R5 not enabled", {7'b0, irq}, 8'h00);
    cyc(0, 0, 1, 0, 0, RA, 8'h00);
    rd(rv); chk("R4 tck", rv, 8'h60);
    cyc(1, 0, 0, 0, 0, RA, 8'h00);
    rd(rv); chk("R4 int", rv, 8'h70);

    // R7 successive acks clear winners in order
    cyc(0, 0, 0, 0, 1, RA, 8'h77);
    cyc(0, 0, 0, 1, 0, RA, 8'h00);
    rd(rv); chk("R7 ack1", rv, 8'h67);
    chk("R7 vec1", vec_addr, 8'h10);
    cyc(0, 0, 0, 1, 0, RA, 8'h00);
    rd(rv); chk("R7 ack2", rv, 8'h47);
    chk("R7 vec2", vec_addr, 8'h18);
    cyc(0, 0, 0, 1, 0, RA, 8'h00);
    rd(rv); chk("R7 ack3", rv, 8'h07);
    chk("R7 idle", {7'b0, irq}, 8'h00);

    // R8 peripheral ack keeps request
    pf = 8'h04; pen = 8'h04;
    cyc(0, 0, 0, 0, 1, RA, 8'h08);
    cyc(0, 0, 0, 1, 0, RA, 8'h00);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    chk("R8 vec", vec_addr, 8'h20);
    rd(rv); chk("R8 reg", rv, 8'h88);
    pf = 0; pen = 0;

    // R9 set beats write and ack
    cyc(0, 0, 0, 0, 1, RA, 8'h01);
    cyc(1, 0, 0, 0, 1, RA, 8'h01);
    rd(rv); chk("R9 set vs write", rv, 8'h11);
    cyc(1, 0, 0, 1, 0, RA, 8'h00);
    rd(rv); chk("R9 set vs ack", rv, 8'h11);

    // R10 ack beats write
    cyc(0, 0, 0, 1, 1, RA, 8'h11);
    rd(rv); chk("R10 ack vs write", rv, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule